// File: doc/BRIEF.md
# Page-Write EEPROM Lane Write Controller

This block models the write-control logic of one byte-wide EEPROM lane that programs a whole page at a time. Three active-low strobes (chip select, output enable, write enable) are sampled on a system clock and decoded into standby, read, write and inhibit. A write pulse can be shaped by either write enable or chip select. The byte address is taken when the second of the two strobes goes low. The data byte is taken from the bus value present just before the first of them goes high.

Accepted bytes collect in a page buffer. A retriggerable window timer restarts at every accepted write start. When the window runs out with no further write, the buffered page is handed to a self-timed programming interval. During that interval the lane ignores new write pulses. Any read returns a polling status built from the last byte accepted. When the interval finishes, the page lands in the storage array and reads return true data again. Both intervals are counted in clock cycles and set by parameters.

Top module: `pgw_lane`

## Requirements
- R1: `dout_en` is 1 only when `cs_n`=0, `oe_n`=0 and `we_n`=1. With `cs_n`=1 (standby), or with `oe_n` and `we_n` both low, it is 0.
- R2: A write is accepted only while `oe_n`=1 and both `cs_n` and `we_n` are low. The byte address is the `addr` value in the cycle the later strobe falls; later address changes have no effect. A pulse with `oe_n`=0 writes nothing.
- R3: The stored byte is the `din` value held just before the first of `cs_n`/`we_n` rises. This holds for pulses shaped by write enable and by chip select. `din` changes at or after that rise are ignored.
- R4: With inputs changed on falling clock edges, polling status first appears at the (WIN_CYC+1)-th falling edge after the falling edge at which the write start was presented, and not before.
- R5: An accepted write start before the window expires restarts the window count from zero. All bytes of the page are then programmed together.
- R6: The programming interval lasts exactly PROG_CYC clock cycles, ends without further input, and is followed by reads that return the newly written data.
- R7: While programming, a read returns {~b[7], b[6:0]}, where b is the last byte accepted, whatever the address.
- R8: The page buffer holds 2**PW bytes (64 by default) indexed by `addr[PW-1:0]`. A write start whose `addr[AW-1:PW]` differs from that of the first byte of the open page is ignored. The array keeps its old value there, and that byte does not become the polled byte.
- R9: Write pulses during programming are ignored. They change no stored byte and start no later programming interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | AW | Byte address |
| din | input | 8 | Data bus, input half |
| dout | output | 8 | Data bus, output half (array data or polling status) |
| dout_en | output | 1 | Drive enable for the output half of the data bus |

## Verification
The assertions assume synchronous strobes that never carry X after reset. They also assume that every write pulse ends well before the page window runs out, so no byte is still being latched when programming starts. The bench drives every strobe on falling clock edges. Its write pulses last two or three cycles against a window of forty. It issues pulses during programming only to check that they are ignored.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    M_STANDBY = 2'd0,
    M_READ    = 2'd1,
    M_WRITE   = 2'd2,
    M_INHIBIT = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/pgw_timer.sv
// Retriggerable interval counter: kick (re)starts it, done marks its last cycle.
module pgw_timer #(
  parameter int CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic run,
  output logic done
);
  localparam int CW = (CYC > 2) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_d;

  assign done = run & (cnt_q == CW'(CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    run_d = run;
    if (kick) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (done) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (run) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run   <= run_d;
    end
  end
endmodule

// File: rtl/pgw_strobe.sv
// Strobe decode and write-pulse edge logic.
module pgw_strobe
  import pgw_pkg::*;
#(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [PW-1:0] idx_in,
  input  logic [7:0]    din,
  input  logic          busy,
  input  logic          page_ok,
  output lane_mode_e    mode,
  output logic          wr_start,
  output logic          wr_end,
  output logic [PW-1:0] cap_idx,
  output logic [7:0]    cap_data
);
  logic act, act_q, pend_q, pend_d;
  logic [7:0] din_q;

  always_comb begin
    if (cs_n)                mode = M_STANDBY;
    else if (!oe_n && we_n)  mode = M_READ;
    else if (oe_n && !we_n)  mode = M_WRITE;
    else                     mode = M_INHIBIT;
  end

  assign act      = (mode == M_WRITE);
  assign wr_start = act & ~act_q & ~busy & page_ok;
  assign wr_end   = pend_q & act_q & ~act;
  assign cap_data = din_q;

  always_comb begin
    pend_d = pend_q;
    if (wr_start)             pend_d = 1'b1;
    else if (act_q && !act)   pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      act_q  <= act;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (act)      din_q   <= din;
    if (wr_start) cap_idx <= idx_in;
  end
endmodule

// File: rtl/pgw_page_buf.sv
// Page collection buffer with one valid flag per byte slot.
module pgw_page_buf #(
  parameter int PW = 6,
  parameter int TW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    open_req,
  input  logic [TW-1:0]           tag_in,
  input  logic                    wr,
  input  logic [PW-1:0]           wr_idx,
  input  logic [7:0]              wr_data,
  input  logic                    clr,
  output logic                    pg_open,
  output logic [TW-1:0]           pg_tag,
  output logic [(1<<PW)-1:0]      pg_vld,
  output logic [(1<<PW)-1:0][7:0] pg_data
);
  localparam int NB = 1 << PW;

  logic          open_d;
  logic [TW-1:0] tag_d;
  logic [NB-1:0] vld_d;

  always_comb begin
    open_d = pg_open;
    tag_d  = pg_tag;
    vld_d  = pg_vld;
    if (clr) begin
      open_d = 1'b0;
      vld_d  = '0;
    end else begin
      if (open_req && !pg_open) begin
        open_d = 1'b1;
        tag_d  = tag_in;
      end
      if (wr) vld_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_open <= 1'b0;
      pg_tag  <= '0;
      pg_vld  <= '0;
    end else begin
      pg_open <= open_d;
      pg_tag  <= tag_d;
      pg_vld  <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) pg_data[wr_idx] <= wr_data;
  end
endmodule

// File: rtl/pgw_lane.sv
// Top: one byte lane with page buffer, window timer and program timer.
module pgw_lane
  import pgw_pkg::*;
#(
  parameter int AW       = 10,
  parameter int PW       = 6,
  parameter int WIN_CYC  = 40,
  parameter int PROG_CYC = 300
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en
);
  localparam int TW    = AW - PW;
  localparam int NB    = 1 << PW;
  localparam int DEPTH = 1 << AW;

  logic rst_meta, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  lane_mode_e            mode;
  logic                  wr_start, wr_end, page_ok;
  logic [PW-1:0]         cap_idx;
  logic [7:0]            cap_data;
  logic                  win_run, win_done, busy, prog_done;
  logic                  pg_open;
  logic [TW-1:0]         pg_tag;
  logic [NB-1:0]         pg_vld;
  logic [NB-1:0][7:0]    pg_data;
  logic [7:0]            last_q;
  logic [7:0]            mem [DEPTH];

  assign page_ok = ~pg_open | (addr[AW-1:PW] == pg_tag);

  pgw_strobe #(.PW(PW)) u_strobe (
    .clk(clk), .rst_n(rst_ni), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .idx_in(addr[PW-1:0]), .din(din), .busy(busy), .page_ok(page_ok),
    .mode(mode), .wr_start(wr_start), .wr_end(wr_end),
    .cap_idx(cap_idx), .cap_data(cap_data)
  );

  pgw_timer #(.CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_ni), .kick(wr_start), .run(win_run), .done(win_done)
  );

  pgw_timer #(.CYC(PROG_CYC)) u_prog (
    .clk(clk), .rst_n(rst_ni), .kick(win_done), .run(busy), .done(prog_done)
  );

  pgw_page_buf #(.PW(PW), .TW(TW)) u_page (
    .clk(clk), .rst_n(rst_ni), .open_req(wr_start), .tag_in(addr[AW-1:PW]),
    .wr(wr_end), .wr_idx(cap_idx), .wr_data(cap_data), .clr(prog_done),
    .pg_open(pg_open), .pg_tag(pg_tag), .pg_vld(pg_vld), .pg_data(pg_data)
  );

  always_ff @(posedge clk) begin
    if (wr_end) last_q <= cap_data;
  end

  always_ff @(posedge clk) begin
    if (prog_done) begin
      for (int i = 0; i < NB; i++) begin
        if (pg_vld[i]) mem[{pg_tag, PW'(i)}] <= pg_data[i];
      end
    end
  end

  assign dout    = busy ? {~last_q[7], last_q[6:0]} : mem[addr];
  assign dout_en = (mode == M_READ);
endmodule

// File: rtl/pgw_lane_chk.sv
module pgw_lane_chk #(
  parameter int PROG_CYC = 300
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       dout_en,
  input logic [7:0] dout,
  input logic       busy,
  input logic       win_run
);
  int blen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     blen <= 0;
    else if (!busy) blen <= 0;
    else            blen <= blen + 1;
  end

  p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dout_en);

  p_prog_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !win_run);

  p_prog_from_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(win_run));

  p_prog_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen == PROG_CYC));

  p_poll_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dout));
endmodule

bind pgw_lane pgw_lane_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout_en(dout_en),
  .dout(dout), .busy(busy), .win_run(win_run)
);

// File: tb/pgw_lane_bench.sv
`timescale 1ns/1ps
module pgw_lane_bench;
  localparam int AW = 10;
  localparam int W  = 40;
  localparam int P  = 300;

  logic clk = 1'b0;
  logic rst_n, cs_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [7:0] din, dout;
  logic dout_en;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pgw_lane #(.AW(AW), .PW(6), .WIN_CYC(W), .PROG_CYC(P)) u_pgw_lane (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_we(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk) begin cs_n = 0; oe_n = 1; we_n = 1; addr = a; din = d; end
    @(negedge clk) we_n = 0;
    @(negedge clk);
    @(negedge clk) we_n = 1;
    @(negedge clk) cs_n = 1;
  endtask

  task automatic wr_cs(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk) begin cs_n = 1; oe_n = 1; we_n = 0; addr = a; din = d; end
    @(negedge clk) cs_n = 0;
    @(negedge clk);
    @(negedge clk) cs_n = 1;
    @(negedge clk) we_n = 1;
  endtask

  task automatic rd_mode(input logic [AW-1:0] a);
    @(negedge clk) begin cs_n = 0; oe_n = 0; we_n = 1; addr = a; end
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    rd_mode(a);
    @(negedge clk);
    chk(dout_en === 1'b1 && dout === exp, req, "read data", {7'd0, dout_en, dout}, {8'd1, exp});
  endtask

  task automatic wait_done(input logic [AW-1:0] a, input logic [7:0] poll,
                           output bit seen, output bit done, output int first);
    seen = 0; done = 0; first = -1;
    rd_mode(a);
    for (int j = 1; j < W + P + 60; j++) begin
      @(negedge clk);
      if (dout === poll) begin
        if (!seen) first = j;
        seen = 1;
      end else if (seen) begin
        done = 1;
        break;
      end
    end
  endtask

  // R1: reset state and read decode
  task automatic t_mode();
    @(negedge clk) begin cs_n = 1; oe_n = 0; we_n = 1; end
    @(negedge clk) chk(dout_en === 1'b0, "R1", "standby drives bus", 16'(dout_en), 16'd0);
    @(negedge clk) cs_n = 0;
    @(negedge clk) chk(dout_en === 1'b1, "R1", "read no drive", 16'(dout_en), 16'd1);
    @(negedge clk) oe_n = 1;
    @(negedge clk) chk(dout_en === 1'b0, "R1", "oe high drives", 16'(dout_en), 16'd0);
    @(negedge clk) begin oe_n = 0; we_n = 0; end
    @(negedge clk) chk(dout_en === 1'b0, "R1", "oe+we low drives", 16'(dout_en), 16'd0);
    @(negedge clk) begin cs_n = 1; oe_n = 1; we_n = 1; end
  endtask

  // R4, R6, R7: window length, program length, polling data
  task automatic t_basic();
    int busy_n = 0;
    @(negedge clk) begin cs_n = 0; oe_n = 1; we_n = 1; addr = 10'h003; din = 8'h5A; end
    @(negedge clk) we_n = 0;
    @(negedge clk);
    @(negedge clk) we_n = 1;
    @(negedge clk) oe_n = 0;
    for (int k = 4; k <= W + P + 2; k++) begin
      @(negedge clk);
      if (k == W)     chk(dout !== 8'hDA, "R4", "busy too early", 16'(dout), 16'h00);
      if (k == W + 1) chk(dout === 8'hDA, "R4", "poll start", 16'(dout), 16'hDA);
      if (dout === 8'hDA) busy_n++;
      if (k == W + 6) chk(dout === 8'hDA, "R7", "poll at other addr", 16'(dout), 16'hDA);
      if (k == W + 4) addr = 10'h155;
      if (k == W + P + 1) chk(dout === 8'h5A, "R6", "data after program", 16'(dout), 16'h5A);
      if (k == W + P) addr = 10'h003;
    end
    chk(busy_n == P, "R6", "program cycles", 16'(busy_n), 16'(P));
    @(negedge clk) cs_n = 1;
  endtask

  // R5: retrigger and whole-page commit
  task automatic t_retrigger();
    bit seen, done, early;
    int first;
    early = 0;
    wr_we(10'h040, 8'h11);
    rd_mode(10'h040);
    for (int j = 0; j < W - 12; j++) begin
      @(negedge clk);
      if (dout === 8'h91) early = 1;
    end
    chk(!early, "R5", "program before window end", 16'(early), 16'd0);
    wr_cs(10'h045, 8'h22);
    wait_done(10'h045, 8'hA2, seen, done, first);
    chk(seen && done, "R5", "retriggered program", 16'({seen, done}), 16'd3);
    chk(first == W - 3, "R5", "window restart", 16'(first), 16'(W - 3));
    rd_chk(10'h040, 8'h11, "R5");
    rd_chk(10'h045, 8'h22, "R5");
  endtask

  // R2, R3: address at later fall, data before first rise
  task automatic t_edges();
    bit seen, done;
    int first;
    @(negedge clk) begin cs_n = 0; oe_n = 1; we_n = 1; addr = 10'h083; din = 8'hA1; end
    @(negedge clk) we_n = 0;
    @(negedge clk) addr = 10'h084;
    @(negedge clk) begin we_n = 1; din = 8'hB2; end
    @(negedge clk) din = 8'hC3;
    @(negedge clk) cs_n = 1;
    @(negedge clk) begin cs_n = 1; we_n = 0; addr = 10'h086; din = 8'h3C; end
    @(negedge clk) cs_n = 0;
    @(negedge clk);
    @(negedge clk) begin cs_n = 1; din = 8'h77; end
    @(negedge clk) we_n = 1;
    wait_done(10'h086, 8'hBC, seen, done, first);
    chk(seen && done, "R3", "program of edge page", 16'({seen, done}), 16'd3);
    rd_chk(10'h083, 8'hA1, "R2");
    rd_chk(10'h086, 8'h3C, "R3");
  endtask

  // R8: byte from another page is dropped
  task automatic t_page_reject();
    bit seen, done;
    int first;
    wr_we(10'h101, 8'h66);
    wait_done(10'h101, 8'hE6, seen, done, first);
    chk(seen && done, "R8", "setup program", 16'({seen, done}), 16'd3);
    wr_we(10'h0C1, 8'h44);
    wr_we(10'h101, 8'h55);
    wait_done(10'h0C1, 8'hC4, seen, done, first);
    chk(seen && done, "R8", "poll of first page byte", 16'({seen, done}), 16'd3);
    rd_chk(10'h0C1, 8'h44, "R8");
    rd_chk(10'h101, 8'h66, "R8");
  endtask

  // R9: pulses during programming are ignored
  task automatic t_busy_ignore();
    bit seen, done, hit;
    int first, bad;
    wr_we(10'h200, 8'h0F);
    rd_mode(10'h200);
    hit = 0;
    for (int j = 0; j < W + 10; j++) begin
      @(negedge clk);
      if (dout === 8'h8F) begin hit = 1; break; end
    end
    chk(hit, "R9", "program started", 16'(hit), 16'd1);
    wr_we(10'h200, 8'hF0);
    wait_done(10'h200, 8'h8F, seen, done, first);
    chk(seen && done, "R9", "program ended", 16'({seen, done}), 16'd3);
    rd_chk(10'h200, 8'h0F, "R9");
    bad = 0;
    for (int j = 0; j < W + P + 10; j++) begin
      @(negedge clk);
      if (dout !== 8'h0F) bad++;
    end
    chk(bad == 0, "R9", "late program after ignored pulse", 16'(bad), 16'd0);
  endtask

  // R2: pulse with output enable low writes nothing
  task automatic t_inhibit();
    bit seen, done;
    int first, bad;
    wr_we(10'h300, 8'h81);
    wait_done(10'h300, 8'h01, seen, done, first);
    chk(seen && done, "R2", "setup program", 16'({seen, done}), 16'd3);
    @(negedge clk) begin cs_n = 0; oe_n = 0; we_n = 1; addr = 10'h300; din = 8'h7E; end
    @(negedge clk) we_n = 0;
    @(negedge clk) chk(dout_en === 1'b0, "R1", "drive while we low", 16'(dout_en), 16'd0);
    @(negedge clk) we_n = 1;
    bad = 0;
    for (int j = 0; j < W + P + 10; j++) begin
      @(negedge clk);
      if (dout !== 8'h81) bad++;
    end
    chk(bad == 0, "R2", "inhibited write changed data", 16'(bad), 16'd0);
  endtask

  initial begin
    rst_n = 0; cs_n = 1; oe_n = 1; we_n = 1; addr = '0; din = '0;
    repeat (4) @(negedge clk);
    chk(dout_en === 1'b0, "R1", "reset drive", 16'(dout_en), 16'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_mode();
    t_basic();
    t_retrigger();
    t_edges();
    t_page_reject();
    t_busy_ignore();
    t_inhibit();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule